// File: doc/BRIEF.md
# Serial Byte Memory Slave with Pause Control

This block is the SPI mode-0 slave side of an 8K x 8 byte memory. It sits in the fast system clock domain and oversamples the four serial pins: chip select, serial clock, serial data in and an active-low pause pin. It turns the serial traffic into reads and writes of a synchronous byte RAM inside the block. A transaction opens when chip select goes low. The first byte is an opcode and the next two bytes carry the address. After that, bytes flow out of the memory or into it until chip select goes high again.

Writes take effect byte by byte, as soon as each byte is complete. There is no page buffer, so a burst may be any length. A 13-bit counter walks the address and wraps from the last location back to zero. Two things gate writes. A write-enable latch is armed by a separate one-byte transaction. An external protect input must also be low.

The pause pin can freeze a transfer part way through a byte and later let it continue exactly where it stopped. The data-out pin has an enable output, so a pad can present it as high impedance.

The serial pins are sampled through a synchronizer that is `SYNC_STAGES` deep. Each half period of the serial clock must therefore last at least `SYNC_STAGES + 3` system clock cycles.

Top module: `spimem_slave`

## Requirements
- R1: Each transaction is framed by chip select low and starts with an 8-bit opcode sent MSB first. Opcode 06h arms the write-enable latch. Opcode 03h starts a read and 02h starts a write. A read or write opcode is followed by a 16-bit address sent MSB first.
- R2: Only the low 13 bits of the 16-bit address field are used. The top three bits have no effect on which location is accessed.
- R3: In a read, the byte at the current address is shifted out MSB first on the eight serial clocks that follow the address. Data out changes on the falling serial clock edge and is meant to be sampled on the rising edge.
- R4: Data in is ignored while read data is being shifted out, and memory contents are unchanged after such a read.
- R5: After each complete data byte the address advances by one, in both reads and writes. From 1FFFh it wraps to 0000h.
- R6: In a write, each byte is stored as soon as its eighth bit has been sampled on a rising serial clock edge. A single transaction may write any number of bytes.
- R7: A data byte is stored only if two conditions hold. The write-enable latch must have been armed by an earlier 06h transaction, and the protect input must be low when the byte completes. The latch clears when any write transaction ends.
- R8: Chip select going high ends any transaction. Any partial byte that has been shifted in at that point is discarded and not stored.
- R9: After any opcode other than 06h, 03h or 02h, the block ignores the serial clock until chip select rises. It drives no data and writes nothing.
- R10: Pause is entered by taking the pause pin low while the serial clock is low, and left by taking it high while the serial clock is low. While paused, serial clock edges have no effect, and the transfer resumes at the same bit.
- R11: Data-out enable is low after reset. It is also low while chip select is high, while paused, and in every phase other than read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, idle low (mode 0) |
| si_i | input | 1 | Serial data from the master |
| hold_n_i | input | 1 | Pause request, active low |
| wp_i | input | 1 | Write protect; high blocks stores |
| so_o | output | 1 | Serial data to the master |
| so_oe_o | output | 1 | Output enable for so_o; low means high impedance |

## Verification
Several corner cases are targeted directly, and each catches a specific kind of bug.

A burst that starts at 1FFFh is read back across the wrap. A counter that does not wrap correctly would return bytes from the wrong locations. A write to an address with the top field bits set is read back through the plain address. A decoder that keeps those bits would miss the location.

Four write cases must leave memory unchanged:
- a write sent without the enable opcode;
- a second write after the latch should have cleared;
- a write with protect high;
- a byte cut short by chip select.

A block that stores too eagerly would overwrite the earlier value in any of these cases.

Pauses are inserted in the middle of a read byte and in the middle of a write byte, with serial clock pulses and noise on data in during the pause. A block that counts those edges would shift the data by bits. Sending an unknown opcode must produce no output enable and no memory change.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_RD,
    ST_WR,
    ST_SKIP
  } eng_state_e;

  localparam logic [7:0] OPC_ARM   = 8'h06;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam int ADDR_FIELD_W = 16;
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[gi]}};
      else        chain <= (chain << 1) | STAGES'(d_i[gi]);
    end
    assign q_o[gi] = chain[STAGES-1];
  end
endmodule

// File: rtl/spimem_pins.sv
module spimem_pins #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic si_i,
  input  logic hold_n_i,
  output logic desel_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic si_o,
  output logic hold_act_o
);
  localparam int NPINS = 4;

  logic [NPINS-1:0] raw, syn;
  logic sck_s, hold_s, sck_q, hold_act;

  assign raw = {cs_n_i, sck_i, si_i, hold_n_i};

  spimem_sync #(.W(NPINS), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  assign desel_o = syn[3];
  assign sck_s   = syn[2];
  assign si_o    = syn[1];
  assign hold_s  = syn[0];

  // Pause state only changes while the serial clock is low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      hold_act <= 1'b0;
    end else begin
      sck_q <= sck_s;
      if (!hold_act && !hold_s && !sck_s)     hold_act <= 1'b1;
      else if (hold_act && hold_s && !sck_s)  hold_act <= 1'b0;
    end
  end

  assign sck_rise_o = sck_s & ~sck_q & ~hold_act;
  assign sck_fall_o = ~sck_s & sck_q & ~hold_act;
  assign hold_act_o = hold_act;

  assert_hold_enter_sck_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_act) |-> $past(!sck_s));
  assert_hold_leave_sck_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_act) |-> $past(!sck_s));
endmodule

// File: rtl/spimem_ram.sv
module spimem_ram #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/spimem_engine.sv
module spimem_engine
  import spimem_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desel_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          si_i,
  input  logic          hold_i,
  input  logic          wp_i,
  input  logic [7:0]    rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output logic          so_o,
  output logic          so_oe_o
);
  localparam int SH_W  = (AW - 1 > 7) ? AW - 1 : 7;
  localparam int ACNT_W = $clog2(ADDR_FIELD_W);
  localparam logic [ACNT_W-1:0] ACNT_LAST = ACNT_W'(ADDR_FIELD_W - 1);

  eng_state_e        state;
  logic [2:0]        bcnt;
  logic [ACNT_W-1:0] acnt;
  logic [SH_W-1:0]   shreg;
  logic [AW-1:0]     addr;
  logic [7:0]        obuf;
  logic              wel, rd_mode, wr_seen, so_q, we_q;
  logic [AW-1:0]     wa_q;
  logic [7:0]        wd_q;
  logic [7:0]        nxt_byte;
  logic [AW-1:0]     nxt_addr;

  assign nxt_byte = {shreg[6:0], si_i};
  assign nxt_addr = {shreg[AW-2:0], si_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_OPC;
      bcnt    <= '0;
      acnt    <= '0;
      shreg   <= '0;
      addr    <= '0;
      obuf    <= '0;
      wel     <= 1'b0;
      rd_mode <= 1'b0;
      wr_seen <= 1'b0;
      so_q    <= 1'b0;
      we_q    <= 1'b0;
      wa_q    <= '0;
      wd_q    <= '0;
    end else begin
      we_q <= 1'b0;
      if (desel_i) begin
        state   <= ST_OPC;
        bcnt    <= '0;
        acnt    <= '0;
        wr_seen <= 1'b0;
        if (wr_seen) wel <= 1'b0;
      end else if (rise_i) begin
        case (state)
          ST_OPC: begin
            shreg <= {shreg[SH_W-2:0], si_i};
            bcnt  <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              case (nxt_byte)
                OPC_ARM:   begin wel <= 1'b1; state <= ST_SKIP; end
                OPC_READ:  begin rd_mode <= 1'b1; state <= ST_ADDR; end
                OPC_WRITE: begin rd_mode <= 1'b0; wr_seen <= 1'b1; state <= ST_ADDR; end
                default:   state <= ST_SKIP;
              endcase
            end
          end
          ST_ADDR: begin
            shreg <= {shreg[SH_W-2:0], si_i};
            acnt  <= acnt + 1'b1;
            if (acnt == ACNT_LAST) begin
              addr  <= nxt_addr;
              state <= rd_mode ? ST_RD : ST_WR;
            end
          end
          ST_RD: begin
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) addr <= addr + 1'b1;
          end
          ST_WR: begin
            shreg <= {shreg[SH_W-2:0], si_i};
            bcnt  <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              we_q <= wel & ~wp_i;
              wa_q <= addr;
              wd_q <= nxt_byte;
              addr <= addr + 1'b1;
            end
          end
          default: ;
        endcase
      end else if (fall_i && state == ST_RD) begin
        if (bcnt == 3'd0) begin
          obuf <= rdata_i;
          so_q <= rdata_i[7];
        end else begin
          so_q <= obuf[3'd7 - bcnt];
        end
      end
    end
  end

  assign raddr_o = addr;
  assign we_o    = we_q;
  assign waddr_o = wa_q;
  assign wdata_o = wd_q;
  assign so_o    = so_q;
  assign so_oe_o = (state == ST_RD) & ~desel_i & ~hold_i;

  assert_desel_resets_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    desel_i |=> (state == ST_OPC && bcnt == 3'd0));
  assert_store_needs_permission_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> $past(wel && !wp_i));
  assert_addr_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!desel_i && rise_i && (state == ST_RD || state == ST_WR) && bcnt == 3'd7
     && addr == {AW{1'b1}}) |=> (addr == '0));
  assert_pause_freezes_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !desel_i) |=> $stable(bcnt) && $stable(acnt));
endmodule

// File: rtl/spimem_slave.sv
module spimem_slave #(
  parameter int ADDR_W = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic si_i,
  input  logic hold_n_i,
  input  logic wp_i,
  output logic so_o,
  output logic so_oe_o
);
  logic desel, rise, fall, si_s, hold_act, we;
  logic [ADDR_W-1:0] raddr, waddr;
  logic [7:0] wdata, rdata;

  spimem_pins #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sck_i(sck_i), .si_i(si_i),
    .hold_n_i(hold_n_i), .desel_o(desel), .sck_rise_o(rise), .sck_fall_o(fall),
    .si_o(si_s), .hold_act_o(hold_act)
  );

  spimem_engine #(.AW(ADDR_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .desel_i(desel), .rise_i(rise), .fall_i(fall),
    .si_i(si_s), .hold_i(hold_act), .wp_i(wp_i), .rdata_i(rdata),
    .raddr_o(raddr), .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
    .so_o(so_o), .so_oe_o(so_oe_o)
  );

  spimem_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk(clk), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata)
  );
endmodule

// File: tb/spimem_slave_tb.sv
`timescale 1ns/1ps
module spimem_slave_tb_top;
  localparam int HP = 30;
  localparam int NVEC = 12;
  // {is_read, address field, data}
  localparam logic [24:0] VECS [NVEC] = '{
    {1'b0, 16'h0010, 8'hA5}, {1'b0, 16'h0011, 8'h3C}, {1'b0, 16'h0100, 8'hFF},
    {1'b0, 16'h1FFE, 8'h81}, {1'b0, 16'h0800, 8'h00}, {1'b0, 16'h0FFF, 8'h7E},
    {1'b1, 16'h0010, 8'hA5}, {1'b1, 16'h0011, 8'h3C}, {1'b1, 16'h0100, 8'hFF},
    {1'b1, 16'h1FFE, 8'h81}, {1'b1, 16'h0800, 8'h00}, {1'b1, 16'h0FFF, 8'h7E}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp = 1'b0;
  logic so, so_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0, oe_seen;
  logic [7:0] rb, rb2, rb3;

  always #2.5 clk = ~clk;

  spimem_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .si_i(si),
    .hold_n_i(hold_n), .wp_i(wp), .so_o(so), .so_oe_o(so_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic r);
    si = b;
    #HP;
    r = so;
    oe_seen = oe_seen | so_oe;
    sck = 1'b1;
    #HP;
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) sbit(tx[i], rx[i]);
  endtask

  task automatic start();
    cs_n = 1'b0;
    #HP;
  endtask

  task automatic stop();
    #HP;
    cs_n = 1'b1;
    #(4 * HP);
  endtask

  task automatic arm();
    logic [7:0] d;
    start(); xfer(8'h06, d); stop();
  endtask

  task automatic wr_raw(input logic [15:0] a, input logic [7:0] v);
    logic [7:0] d;
    start(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d); xfer(v, d); stop();
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    logic [7:0] d;
    start(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d); xfer(8'h00, v); stop();
  endtask

  initial begin
    logic [7:0] d;
    logic b;
    #(20 * 5);
    rst_n = 1'b1;
    #(10 * 5);
    check(so_oe == 1'b0, "R11 reset oe", so_oe, 0);

    // Vector table: writes then read-backs (R1 R3 R6)
    for (int i = 0; i < NVEC; i++) begin
      if (!VECS[i][24]) begin
        arm();
        wr_raw(VECS[i][23:8], VECS[i][7:0]);
      end else begin
        rd(VECS[i][23:8], rb);
        check(rb == VECS[i][7:0], "R1 R3 R6 vector read", rb, VECS[i][7:0]);
      end
    end
    cs_n = 1'b1;
    check(so_oe == 1'b0, "R11 oe after deselect", so_oe, 0);

    // R5: burst write across wrap, then burst read across wrap
    arm();
    start(); xfer(8'h02, d); xfer(8'h1F, d); xfer(8'hFF, d);
    xfer(8'h11, d); xfer(8'h22, d); xfer(8'h33, d); stop();
    start(); xfer(8'h03, d); xfer(8'h1F, d); xfer(8'hFF, d);
    xfer(8'h00, rb); xfer(8'h00, rb2); xfer(8'h00, rb3); stop();
    check(rb == 8'h11, "R5 wrap read 1FFF", rb, 8'h11);
    check(rb2 == 8'h22, "R5 wrap read 0000", rb2, 8'h22);
    check(rb3 == 8'h33, "R6 burst third byte 0001", rb3, 8'h33);
    rd(16'h0000, rb);
    check(rb == 8'h22, "R5 single read 0000", rb, 8'h22);

    // R2: top address bits ignored
    arm(); wr_raw(16'hE005, 8'h5A);
    rd(16'h0005, rb);
    check(rb == 8'h5A, "R2 top bits ignored write", rb, 8'h5A);
    rd(16'h2005, rb);
    check(rb == 8'h5A, "R2 top bits ignored read", rb, 8'h5A);

    // R7: write without arming
    wr_raw(16'h0010, 8'h11);
    rd(16'h0010, rb);
    check(rb == 8'hA5, "R7 no arm", rb, 8'hA5);

    // R7: latch cleared after a write transaction
    arm(); wr_raw(16'h0020, 8'h44);
    wr_raw(16'h0020, 8'h55);
    rd(16'h0020, rb);
    check(rb == 8'h44, "R7 latch cleared", rb, 8'h44);

    // R7: protect input blocks
    wp = 1'b1; arm(); wr_raw(16'h0020, 8'h66); wp = 1'b0;
    rd(16'h0020, rb);
    check(rb == 8'h44, "R7 protect", rb, 8'h44);

    // R9: unknown opcode
    arm();
    oe_seen = 1'b0;
    start(); xfer(8'hAB, d); xfer(8'h00, d); xfer(8'h10, d); xfer(8'h00, d); stop();
    check(oe_seen == 1'b0, "R9 no output enable", oe_seen, 0);
    rd(16'h0010, rb);
    check(rb == 8'hA5, "R9 memory untouched", rb, 8'hA5);

    // R8: partial byte discarded
    arm();
    start(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h11, d);
    for (int i = 0; i < 5; i++) sbit(1'b0, b);
    stop();
    rd(16'h0011, rb);
    check(rb == 8'h3C, "R8 partial byte", rb, 8'h3C);

    // R10: pause during write
    arm(); wr_raw(16'h0040, 8'hC3);
    arm(); wr_raw(16'h0041, 8'h96);
    arm();
    start(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h42, d);
    sbit(1'b0, b); sbit(1'b1, b); sbit(1'b0, b);
    hold_n = 1'b0; #HP;
    for (int i = 0; i < 4; i++) begin si = ~si; sck = 1'b1; #HP; sck = 1'b0; #HP; end
    hold_n = 1'b1; #HP;
    sbit(1'b1, b); sbit(1'b1, b); sbit(1'b1, b); sbit(1'b1, b); sbit(1'b0, b);
    stop();
    rd(16'h0042, rb);
    check(rb == 8'h5E, "R10 pause in write", rb, 8'h5E);

    // R10 R11 R4: pause during read with noise on data in
    start(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h40, d);
    for (int i = 7; i >= 4; i--) sbit(1'b1, rb[i]);
    hold_n = 1'b0; #HP;
    check(so_oe == 1'b0, "R11 oe low while paused", so_oe, 0);
    for (int i = 0; i < 3; i++) begin sck = 1'b1; #HP; sck = 1'b0; #HP; end
    hold_n = 1'b1; #HP;
    for (int i = 3; i >= 0; i--) sbit(1'b1, rb[i]);
    xfer(8'hFF, rb2);
    stop();
    check(rb == 8'hC3, "R10 pause in read byte 1", rb, 8'hC3);
    check(rb2 == 8'h96, "R3 second read byte", rb2, 8'h96);
    rd(16'h0040, rb);
    check(rb == 8'hC3, "R4 data in ignored in read", rb, 8'hC3);
    rd(16'h0041, rb);
    check(rb == 8'h96, "R4 data in ignored next byte", rb, 8'h96);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(500_000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule